// File: doc/BRIEF.md
# Chaotic Boltzmann Neuron Update Engine

This block advances a small, fully connected network of chaotic binary neurons by one step at a time. Each neuron holds a spin bit, a phase accumulator and a signed local field. On a step the accumulators of all neurons move together. A neuron moves forward while its spin is 0 and backward while its spin is 1, by its local field scaled by a temperature. A neuron whose accumulator reaches the threshold toggles its spin. The block then repairs the local fields of the other neurons, but only for the neurons that toggled, one toggled neuron at a time. Each repair reads one row of a symmetric weight memory that the surrounding chip provides.

The temperature is applied in two parts. The field is first shifted right arithmetically by a power-of-two amount, then multiplied by a narrow unsigned factor. This replaces a full division. A controller that runs an annealing or reservoir workload supplies the two parts with each step request and reads the spins and fields back after the step-done pulse.

Top module: `cbm_engine`

## Requirements
- R1: While reset is low, or on the first sample after reset is released, all spins and all fields are 0. The block then spends N*N cycles loading the fields, and `ready` rises afterwards. At that point field i equals minus the sum of W(i,j) over all j other than i.
- R2: A step is taken when `step_go` is high while `ready` is high. Every neuron adds to its accumulator the value d = (Z >>> temp_shift) * temp_factor, using the field Z from before the step and the temperature inputs sampled at the step. It adds +d when its spin is 0 and -d when its spin is 1.
- R3: If the new accumulator value would be negative, the accumulator holds 0 instead, and the spin is unchanged.
- R4: If the new accumulator value is 256 or more, the spin toggles and the accumulator is cleared to 0. Otherwise the accumulator keeps the new value.
- R5: When a step completes, every field i equals the sum over j other than i of W(i,j)*(2*S(j)-1). The diagonal weight W(i,i) has no effect on any field.
- R6: The step is done only after the pending set of toggled neurons has been emptied. Each toggled neuron costs exactly N cycles. `step_done` is high in the cycle that lies 3 + F*N clock edges after the edge that sampled `step_go`, where F is the number of neurons that toggled.
- R7: `step_done` is a single-cycle pulse. `ready` is low from the step request until the pulse has ended. A `step_go` that arrives while `ready` is low is ignored and does not start another step.
- R8: The weight read address is {row i, column j}: the row index sits in the upper clog2(N) bits and the column index in the lower clog2(N) bits. `w_data` is the signed weight W(i,j), valid in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_go | input | 1 | Step request, taken while ready is high |
| temp_shift | input | 5 | Power-of-two part of the temperature (arithmetic right shift of the field) |
| temp_factor | input | 6 | Unsigned multiplier applied after the shift |
| w_addr | output | 2*clog2(N) | Weight read address {row, column} |
| w_data | input | WW | Signed weight returned for w_addr in the same cycle |
| spins | output | N | Spin of each neuron |
| fields | output | N*ZW | Local field of each neuron; neuron i occupies bits i*ZW upward |
| ready | output | 1 | Idle and able to accept a step |
| step_done | output | 1 | One-cycle pulse when a step has finished |

## Verification
The due cycle of every result depends on how many neurons toggle in that step. The bench works out F from its own model of the accumulators first. It then counts clock edges from the edge that sampled the request until it sees `step_done` at a falling edge, and expects exactly 3 + F*N. Spins and fields are compared against a model that rebuilds every field densely from the weight formula. This comparison is made only in that done cycle, when all repairs have landed, and never in between. Reset values are checked on the first falling edge after reset is released. The post-load fields are checked once `ready` has risen. The check that a request arriving while busy is ignored waits several idle cycles afterwards and confirms that the state has not moved.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_UPD,
    ST_PROP,
    ST_DONE
  } eng_st_t;

  localparam int FLIP_LEVEL = 256;
endpackage

// File: rtl/cbm_neuron.sv
module cbm_neuron
  import cbm_pkg::*;
#(
  parameter int ZW  = 19,
  parameter int FW  = 6,
  parameter int SHW = 5,
  parameter int XW  = ZW + FW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_en,
  input  logic [SHW-1:0]       t_shift,
  input  logic [FW-1:0]        t_factor,
  input  logic                 fld_en,
  input  logic signed [ZW-1:0] fld_delta,
  output logic                 spin_o,
  output logic signed [ZW-1:0] field_o,
  output logic                 flip_o
);
  localparam int PW = ZW + FW + 1;
  localparam logic signed [XW-1:0] FLIP_X = XW'(FLIP_LEVEL);

  logic signed [ZW-1:0] z_q, z_d, z_sh;
  logic signed [XW-1:0] x_q, x_d, mag, step_amt, x_sum;
  logic signed [PW-1:0] prod;
  logic                 s_q, s_d, hit;

  always_comb begin
    z_sh     = z_q >>> t_shift;
    prod     = z_sh * $signed({1'b0, t_factor});
    mag      = {{(XW-PW){prod[PW-1]}}, prod};
    step_amt = s_q ? -mag : mag;
    x_sum    = x_q + step_amt;
    hit      = upd_en && !x_sum[XW-1] && (x_sum >= FLIP_X);
    x_d = x_q;
    s_d = s_q;
    z_d = z_q;
    if (upd_en) begin
      if (x_sum[XW-1]) begin
        x_d = '0;
      end else if (hit) begin
        x_d = '0;
        s_d = ~s_q;
      end else begin
        x_d = x_sum;
      end
    end
    if (fld_en) z_d = z_q + fld_delta;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      s_q <= 1'b0;
      z_q <= '0;
    end else begin
      if (upd_en) begin
        x_q <= x_d;
        s_q <= s_d;
      end
      if (fld_en) z_q <= z_d;
    end
  end

  assign spin_o  = s_q;
  assign field_o = z_q;
  assign flip_o  = hit;

  AST_ACC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !x_q[XW-1] && (x_q < FLIP_X)); // R3
  AST_SPIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(s_q)); // R4
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_en |=> $stable(z_q)); // R5
endmodule

// File: rtl/cbm_pick.sv
module cbm_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |req;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) idx = IW'(k);
    end
  end
endmodule

// File: rtl/cbm_engine.sv
module cbm_engine
  import cbm_pkg::*;
#(
  parameter int N   = 4,
  parameter int WW  = 8,
  parameter int ZW  = 19,
  parameter int FW  = 6,
  parameter int SHW = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          step_go,
  input  logic [SHW-1:0]                temp_shift,
  input  logic [FW-1:0]                 temp_factor,
  output logic [2*((N>1)?$clog2(N):1)-1:0] w_addr,
  input  logic signed [WW-1:0]          w_data,
  output logic [N-1:0]                  spins,
  output logic [N*ZW-1:0]               fields,
  output logic                          ready,
  output logic                          step_done
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int XW = ZW + FW + 2;
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  eng_st_t st_q, st_d;
  logic [IW-1:0] row_q, row_d, col_q, col_d, pick_idx;
  logic [N-1:0]  pend_q, pend_d, flip_now, spin_w, fld_sel;
  logic          pick_any, upd_all;
  logic signed [ZW-1:0] w_ext, delta;

  cbm_pick #(.N(N), .IW(IW)) u_pick (
    .req(pend_q), .idx(pick_idx), .any(pick_any)
  );

  // next-state
  always_comb begin
    st_d   = st_q;
    row_d  = row_q;
    col_d  = col_q;
    pend_d = pend_q;
    case (st_q)
      ST_INIT: begin
        if (col_q == LAST) begin
          col_d = '0;
          if (row_q == LAST) begin
            row_d = '0;
            st_d  = ST_IDLE;
          end else begin
            row_d = row_q + 1'b1;
          end
        end else begin
          col_d = col_q + 1'b1;
        end
      end
      ST_IDLE: if (step_go) st_d = ST_UPD;
      ST_UPD: begin
        pend_d = flip_now;
        row_d  = '0;
        st_d   = ST_PROP;
      end
      ST_PROP: begin
        if (!pick_any) begin
          st_d = ST_DONE;
        end else if (row_q == LAST) begin
          row_d            = '0;
          pend_d[pick_idx] = 1'b0;
        end else begin
          row_d = row_q + 1'b1;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // field datapath
  assign w_ext   = {{(ZW-WW){w_data[WW-1]}}, w_data};
  assign upd_all = (st_q == ST_UPD);

  always_comb begin
    fld_sel = '0;
    delta   = '0;
    w_addr  = {row_q, col_q};
    case (st_q)
      ST_INIT: begin
        delta = -w_ext;
        if (row_q != col_q) fld_sel[row_q] = 1'b1;
      end
      ST_PROP: begin
        w_addr = {row_q, pick_idx};
        delta  = spin_w[pick_idx] ? (w_ext <<< 1) : -(w_ext <<< 1);
        if (pick_any && (row_q != pick_idx)) fld_sel[row_q] = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_INIT;
      row_q  <= '0;
      col_q  <= '0;
      pend_q <= '0;
    end else begin
      st_q   <= st_d;
      row_q  <= row_d;
      col_q  <= col_d;
      pend_q <= pend_d;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_neuron
    cbm_neuron #(.ZW(ZW), .FW(FW), .SHW(SHW), .XW(XW)) u_n (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (upd_all),
      .t_shift  (temp_shift),
      .t_factor (temp_factor),
      .fld_en   (fld_sel[g]),
      .fld_delta(delta),
      .spin_o   (spin_w[g]),
      .field_o  (fields[g*ZW +: ZW]),
      .flip_o   (flip_now[g])
    );
  end

  assign spins     = spin_w;
  assign ready     = (st_q == ST_IDLE);
  assign step_done = (st_q == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !step_done); // R7
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> (pend_q == '0)); // R6
  AST_PEND_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_UPD) |=> ($countones(pend_q) <= $countones($past(pend_q)))); // R6
  AST_BUSY_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && step_go) |=> !ready); // R7
endmodule

// File: tb/sim_cbm_engine.sv
module sim_cbm_engine;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int WW = 8;
  localparam int ZW = 19;
  localparam int IW = 2;
  localparam int NV = 9;
  // each entry: {shift[10:6], factor[5:0]}
  localparam logic [10:0] VEC [0:NV-1] = '{
    {5'd0, 6'd20}, {5'd0, 6'd5}, {5'd1, 6'd40}, {5'd2, 6'd63}, {5'd0, 6'd0},
    {5'd3, 6'd63}, {5'd0, 6'd12}, {5'd18, 6'd63}, {5'd0, 6'd33}
  };

  logic clk = 1'b0, rst_n = 1'b0, step_go = 1'b0;
  logic [4:0] temp_shift = '0;
  logic [5:0] temp_factor = '0;
  logic [2*IW-1:0] w_addr;
  logic signed [WW-1:0] w_data;
  logic [N-1:0] spins;
  logic [N*ZW-1:0] fields;
  logic ready, step_done;

  int checks = 0, errors = 0;
  bit ended = 1'b0;
  int ms [N];
  int mx [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  cbm_engine #(.N(N), .WW(WW), .ZW(ZW)) u0 (
    .clk(clk), .rst_n(rst_n), .step_go(step_go), .temp_shift(temp_shift),
    .temp_factor(temp_factor), .w_addr(w_addr), .w_data(w_data), .spins(spins),
    .fields(fields), .ready(ready), .step_done(step_done)
  );

  // R8: address {row, column}; diagonal holds a large value that must be ignored (R5)
  function automatic int wgt(int i, int j);
    if (i == j) return 100;
    return (((i + j) % 2) != 0 ? -9 : 5) + ((i * j) % 3);
  endfunction

  always_comb w_data = WW'(wgt(int'(w_addr[2*IW-1:IW]), int'(w_addr[IW-1:0])));

  function automatic int mfield(int i);
    int s = 0;
    for (int j = 0; j < N; j++) if (j != i) s += wgt(i, j) * (2 * ms[j] - 1);
    return s;
  endfunction

  function automatic int dut_field(int i);
    return int'($signed(fields[i*ZW +: ZW]));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic check_state(string req);
    for (int i = 0; i < N; i++) begin
      chk(spins[i] == ms[i][0], {req, " spin"}, int'(spins[i]), ms[i]);
      chk(dut_field(i) == mfield(i), {req, " field"}, dut_field(i), mfield(i));
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin ms[i] = 0; mx[i] = 0; end
  endtask

  // one step; poke sends an extra request while busy (R7)
  task automatic do_step(int sh, int f, bit poke);
    int fl = 0, cnt, z [N];
    for (int i = 0; i < N; i++) z[i] = mfield(i);
    for (int i = 0; i < N; i++) begin
      int d = (z[i] >>> sh) * f;
      int xs = mx[i] + (ms[i] != 0 ? -d : d);
      if (xs < 0) mx[i] = 0;                                  // R3
      else if (xs >= 256) begin mx[i] = 0; ms[i] ^= 1; fl++; end // R4
      else mx[i] = xs;                                        // R2
    end
    @(negedge clk);
    temp_shift = 5'(sh); temp_factor = 6'(f); step_go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    step_go = 1'b0;
    cnt = 1;
    chk(!ready, "R7 busy after go", int'(ready), 0);
    while (!step_done && cnt < 200) begin
      if (poke && cnt == 2) step_go = 1'b1; else step_go = 1'b0;
      @(posedge clk); @(negedge clk); cnt++;
    end
    step_go = 1'b0;
    chk(cnt == 3 + fl * N, "R6 done latency", cnt, 3 + fl * N);
    check_state("R5 R2");
    @(negedge clk);
    chk(!step_done && ready, "R7 pulse ends", int'(step_done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: first sample after release
    for (int i = 0; i < N; i++) begin
      chk(dut_field(i) == 0, "R1 field cleared", dut_field(i), 0);
      chk(spins[i] == 1'b0, "R1 spin cleared", int'(spins[i]), 0);
    end
    chk(!ready, "R1 loading", int'(ready), 0);
    begin
      int c = 0;
      while (!ready && c < 100) begin @(negedge clk); c++; end
      chk(c == N * N, "R1 load cycles", c, N * N);
    end
    check_state("R1 initial");

    for (int p = 0; p < 2; p++)
      for (int v = 0; v < NV; v++)
        do_step(int'(VEC[v][10:6]), int'(VEC[v][5:0]), 1'b0);

    // R7: request during a busy step is ignored
    do_step(0, 20, 1'b1);
    repeat (5) @(negedge clk);
    chk(ready && !step_done, "R7 no extra step", int'(ready), 1);
    check_state("R7 unchanged");

    // R3: zero factor moves nothing
    do_step(0, 0, 1'b0);

    // R1: reset in the middle of a step
    @(negedge clk);
    temp_shift = '0; temp_factor = 6'd63; step_go = 1'b1;
    @(negedge clk); step_go = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(spins == '0, "R1 reset spins", int'(spins), 0);
    chk(dut_field(0) == 0, "R1 reset field", dut_field(0), 0);
    rst_n = 1'b1;
    model_reset();
    while (!ready) @(negedge clk);
    check_state("R1 reload");
    do_step(0, 20, 1'b0);
    do_step(2, 50, 1'b0);
    finish_run();
  end
endmodule